// File: doc/BRIEF.md
# Snoop-hit write-back bus sequencer

This block is the bus-side controller of a write-back data cache. An external agent takes the address bus with `addr_hold` and presents a snoop: a one-cycle `snp_strobe` together with the snooped line address and an invalidate request flag. The block looks the line up through a simple tag stub. The stub returns its result combinationally in the same cycle. If the line is held modified, the block raises `hit_mod`. It then writes the whole line back to memory as four doubleword transfers, and the system may acknowledge these with `brdy` as one burst or with `rdy` as separate single cycles.

`hit_mod` covers the whole write-back and drops on the edge that samples the last acknowledge. One idle clock always precedes the first address strobe of a snoop write-back, so the system can still back the cycle off with `backoff` while it holds the address. A back-off aborts the write-back, which then restarts from the first doubleword. A snoop that lands while a line fill is still running is looked up at once. Its write-back waits until the fill has finished. When the write-back completes, or when a snoop hits an unmodified line with invalidate set, the block sends a state update back to the tag stub. All control signals are active high.

Top module: `snoop_wb_sequencer`

## Requirements
- R1: A snoop accepted (`snp_strobe`, `addr_hold`, block idle) with `tag_hit` high and `tag_state` = 3 (modified) sets `hit_mod` from the next cycle. `hit_mod` stays high until the edge that samples the acknowledge of the fourth doubleword and is low from the following cycle. Without back-off or fill, `hit_mod` is high for 6 cycles in burst mode.
- R2: A snoop that misses, or that hits `tag_state` 1 (shared) or 2 (exclusive), never raises `hit_mod` and issues no `bus_start`. A hit of that kind with `snp_inv` high gives a one-cycle `upd_valid` with `upd_state` = 0 (invalid) and `upd_line` equal to the snooped line in the cycle after the snoop. With `snp_inv` low it gives no update.
- R3: A `snp_strobe` while `addr_hold` is low is ignored: no `hit_mod`, no bus cycle, no update.
- R4: `bus_start` is never high in a cycle where `fill_busy` is high, or in the cycle right after one where it was high. At least one idle cycle lies between the rise of `hit_mod` and the first `bus_start`.
- R5: The write-back drives `bus_addr` = {line, dword index, 2'b00}, so the dword index sits in `bus_addr[3:2]`, in the order 0, 1, 2, 3. `bus_write` is high with every `bus_start` and transfer. `bus_last` is high exactly once per write-back, in the transfer of dword 3. With `brdy` acknowledges there is a single `bus_start`.
- R6: An `rdy` acknowledge ends a single transfer. The `bus_start` for the next dword comes in the very next cycle with no idle clock, so a non-burst write-back holds `hit_mod` for 9 cycles and issues four `bus_start` pulses.
- R7: `backoff` high aborts the write-back. While it is high, `bus_start` stays low and `hit_mod` stays high. After release, the write-back restarts with a `bus_start` for dword 0.
- R8: In the cycle where `hit_mod` has just fallen, `upd_valid` is high with `upd_state` = 0 (invalid) if the snoop had `snp_inv` set, or 1 (shared) otherwise.
- R9: A modified-line snoop accepted while `fill_busy` is high raises `hit_mod` at once. The write-back starts only after `fill_busy` has dropped.
- R10: During and right after reset, `hit_mod`, `bus_start`, `bus_last` and `upd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hold | input | 1 | External agent holds the address bus |
| snp_strobe | input | 1 | Snoop request strobe |
| snp_inv | input | 1 | Snoop asks for invalidation |
| snp_line | input | AW-4 | Snooped line address |
| tag_hit | input | 1 | Tag stub: line present |
| tag_state | input | 2 | Tag stub: line state (0 invalid, 1 shared, 2 exclusive, 3 modified) |
| fill_busy | input | 1 | A line fill is in progress on the bus |
| rdy | input | 1 | Single-transfer acknowledge |
| brdy | input | 1 | Burst-transfer acknowledge |
| backoff | input | 1 | Abort the current cycle |
| hit_mod | output | 1 | Snoop hit a modified line |
| bus_start | output | 1 | Address strobe of a write-back cycle |
| bus_last | output | 1 | Last transfer of the write-back |
| bus_write | output | 1 | Cycle is a write |
| bus_addr | output | AW | Write-back doubleword address |
| upd_valid | output | 1 | Tag state update strobe |
| upd_state | output | 2 | New line state |
| upd_line | output | AW-4 | Line being updated |

## Verification
The assertions assume that snoops arrive only while the block is idle. They also assume that `fill_busy` does not rise during a snoop write-back, and that `rdy` and `brdy` are only driven while a transfer is open. The bench keeps to this. Each scenario waits for the previous write-back to finish before it sends the next snoop. Fill activity is raised only before the snoop. A responder drives acknowledges only in the cycles after it has seen a `bus_start`, and back-off only in place of an acknowledge.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    LS_INVALID = 2'd0,
    LS_SHARED  = 2'd1,
    LS_EXCL    = 2'd2,
    LS_MOD     = 2'd3
  } line_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_PEND,
    SQ_ISSUE,
    SQ_XFER
  } seq_state_e;
endpackage

// File: rtl/swb_snoop_capture.sv
module swb_snoop_capture
  import swb_pkg::*;
#(
  parameter int LW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seq_idle,
  input  logic          addr_hold,
  input  logic          snp_strobe,
  input  logic          snp_inv,
  input  logic [LW-1:0] snp_line,
  input  logic          tag_hit,
  input  logic [1:0]    tag_state,
  output logic          mod_start,
  output logic          plain_inval,
  output logic [LW-1:0] line_q,
  output logic          inv_q
);
  logic          accept;
  logic          is_mod;
  logic [LW-1:0] line_d;
  logic          inv_d;

  always_comb begin
    accept      = seq_idle & addr_hold & snp_strobe;
    is_mod      = tag_hit & (tag_state == LS_MOD);
    mod_start   = accept & is_mod;
    plain_inval = accept & tag_hit & ~is_mod & snp_inv;
    line_d      = accept ? snp_line : line_q;
    inv_d       = accept ? snp_inv : inv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      inv_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      inv_q  <= inv_d;
    end
  end
endmodule

// File: rtl/swb_wb_seq.sv
module swb_wb_seq
  import swb_pkg::*;
#(
  parameter int LINE_DW = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       fill_busy,
  input  logic                       rdy,
  input  logic                       brdy,
  input  logic                       backoff,
  output logic                       idle,
  output logic                       hit_mod,
  output logic                       bus_start,
  output logic                       bus_last,
  output logic                       bus_write,
  output logic [$clog2(LINE_DW)-1:0] dw_idx,
  output logic                       finish
);
  localparam int DWB = $clog2(LINE_DW);
  localparam logic [DWB-1:0] LAST_DW = DWB'(LINE_DW - 1);

  seq_state_e     state_q, state_d;
  logic [DWB-1:0] dw_q, dw_d;
  logic           hitm_q, hitm_d;
  logic           ack;

  always_comb begin
    state_d = state_q;
    dw_d    = dw_q;
    hitm_d  = hitm_q;
    finish  = 1'b0;
    ack     = rdy | brdy;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_PEND;
          hitm_d  = 1'b1;
          dw_d    = '0;
        end
      end
      SQ_PEND: begin
        dw_d = '0;
        if (!fill_busy && !backoff) state_d = SQ_ISSUE;
      end
      SQ_ISSUE: begin
        if (backoff) begin
          state_d = SQ_PEND;
          dw_d    = '0;
        end else begin
          state_d = SQ_XFER;
        end
      end
      SQ_XFER: begin
        if (backoff) begin
          state_d = SQ_PEND;
          dw_d    = '0;
        end else if (ack) begin
          if (dw_q == LAST_DW) begin
            state_d = SQ_IDLE;
            hitm_d  = 1'b0;
            finish  = 1'b1;
          end else begin
            dw_d    = dw_q + 1'b1;
            state_d = brdy ? SQ_XFER : SQ_ISSUE;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      dw_q    <= '0;
      hitm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dw_q    <= dw_d;
      hitm_q  <= hitm_d;
    end
  end

  assign idle      = (state_q == SQ_IDLE);
  assign hit_mod   = hitm_q;
  assign bus_start = (state_q == SQ_ISSUE) & ~backoff;
  assign bus_last  = (state_q == SQ_XFER) & (dw_q == LAST_DW);
  assign bus_write = (state_q == SQ_ISSUE) | (state_q == SQ_XFER);
  assign dw_idx    = dw_q;

  // R4: an idle clock separates any fill activity from the address strobe
  p_idle_before_ads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> (!fill_busy && !$past(fill_busy)));

  // R1: the modified-hit flag holds until the final acknowledge
  p_hitm_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hitm_q && !finish) |=> hitm_q);

  p_hitm_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !hitm_q);

  // R7: no strobe under back-off, restart from dword 0 with flag kept
  p_no_ads_boff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    backoff |-> !bus_start);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff && state_q == SQ_XFER) |=> (dw_q == '0 && hitm_q));
endmodule

// File: rtl/snoop_wb_sequencer.sv
module snoop_wb_sequencer
  import swb_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LINE_DW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_hold,
  input  logic               snp_strobe,
  input  logic               snp_inv,
  input  logic [AW-5:0]      snp_line,
  input  logic               tag_hit,
  input  logic [1:0]         tag_state,
  input  logic               fill_busy,
  input  logic               rdy,
  input  logic               brdy,
  input  logic               backoff,
  output logic               hit_mod,
  output logic               bus_start,
  output logic               bus_last,
  output logic               bus_write,
  output logic [AW-1:0]      bus_addr,
  output logic               upd_valid,
  output logic [1:0]         upd_state,
  output logic [AW-5:0]      upd_line
);
  localparam int DWB  = $clog2(LINE_DW);
  localparam int OFFB = DWB + 2;
  localparam int LW   = AW - OFFB;

  logic           seq_idle;
  logic           mod_start;
  logic           plain_inval;
  logic [LW-1:0]  line_q;
  logic           inv_q;
  logic [DWB-1:0] dw_idx;
  logic           finish;
  logic           upd_valid_q, upd_valid_d;
  logic [1:0]     upd_state_q, upd_state_d;

  swb_snoop_capture #(.LW(LW)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_idle    (seq_idle),
    .addr_hold   (addr_hold),
    .snp_strobe  (snp_strobe),
    .snp_inv     (snp_inv),
    .snp_line    (snp_line),
    .tag_hit     (tag_hit),
    .tag_state   (tag_state),
    .mod_start   (mod_start),
    .plain_inval (plain_inval),
    .line_q      (line_q),
    .inv_q       (inv_q)
  );

  swb_wb_seq #(.LINE_DW(LINE_DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (mod_start),
    .fill_busy (fill_busy),
    .rdy       (rdy),
    .brdy      (brdy),
    .backoff   (backoff),
    .idle      (seq_idle),
    .hit_mod   (hit_mod),
    .bus_start (bus_start),
    .bus_last  (bus_last),
    .bus_write (bus_write),
    .dw_idx    (dw_idx),
    .finish    (finish)
  );

  always_comb begin
    upd_valid_d = finish | plain_inval;
    upd_state_d = (finish && !inv_q) ? LS_SHARED : LS_INVALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid_q <= 1'b0;
      upd_state_q <= LS_INVALID;
    end else begin
      upd_valid_q <= upd_valid_d;
      upd_state_q <= upd_state_d;
    end
  end

  assign upd_valid = upd_valid_q;
  assign upd_state = upd_state_q;
  assign upd_line  = line_q;
  assign bus_addr  = {line_q, dw_idx, 2'b00};

  // R2: a snoop that is not a modified hit leaves the flag low
  p_quiet_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_strobe && addr_hold && seq_idle && !(tag_hit && tag_state == 2'd3))
      |=> !hit_mod);

  // R3: a strobe without the address hold is ignored
  p_ignore_nohold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_strobe && !addr_hold && !hit_mod) |=> !hit_mod);

  // R8: the state update accompanies the fall of the flag
  p_update_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hit_mod) |-> upd_valid);
endmodule

// File: tb/snoop_wb_sequencer_test.sv
module snoop_wb_sequencer_test;
  localparam int AW = 32;
  localparam int LW = AW - 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          addr_hold, snp_strobe, snp_inv, tag_hit, fill_busy;
  logic [LW-1:0] snp_line;
  logic [1:0]    tag_state;
  logic          rdy, brdy, backoff;
  logic          hit_mod, bus_start, bus_last, bus_write, upd_valid;
  logic [AW-1:0] bus_addr;
  logic [1:0]    upd_state;
  logic [LW-1:0] upd_line;

  always #10 clk = ~clk;

  snoop_wb_sequencer #(.AW(AW), .LINE_DW(4)) uut (
    .clk(clk), .rst_n(rst_n), .addr_hold(addr_hold), .snp_strobe(snp_strobe),
    .snp_inv(snp_inv), .snp_line(snp_line), .tag_hit(tag_hit),
    .tag_state(tag_state), .fill_busy(fill_busy), .rdy(rdy), .brdy(brdy),
    .backoff(backoff), .hit_mod(hit_mod), .bus_start(bus_start),
    .bus_last(bus_last), .bus_write(bus_write), .bus_addr(bus_addr),
    .upd_valid(upd_valid), .upd_state(upd_state), .upd_line(upd_line)
  );

  typedef struct {
    logic [1:0]    st;
    logic [LW-1:0] line;
  } upd_t;

  logic [AW-1:0] exp_addr[$];
  upd_t          exp_upd[$];

  int checks = 0;
  int errors = 0;

  bit nb_mode = 1'b0;
  int boff_at = -1, boff_len = 0, boff_left = 0, ack_cnt = 0;
  bit open = 1'b0;
  int exp_len = -1;
  int hitm_cnt = 0, blast_cnt = 0, wb_done = 0;
  bit hitm_prev = 1'b0, fill_prev = 1'b0;
  logic [AW-1:0] e_addr;
  upd_t          e_upd;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor and responder
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (bus_start) begin
        if (exp_addr.size() == 0) begin
          chk(1'b0, "R5", "unexpected bus_start", bus_addr, 0);
        end else begin
          e_addr = exp_addr.pop_front();
          chk(bus_addr == e_addr, nb_mode ? "R6" : "R5", "strobe address", bus_addr, e_addr);
        end
        chk(!fill_busy && !fill_prev, "R4", "strobe near fill", {fill_prev, fill_busy}, 0);
        chk(bus_write, "R5", "write on strobe", bus_write, 1);
      end
      if (bus_last) begin
        blast_cnt++;
        chk(bus_addr[3:2] == 2'd3 && bus_write, "R5", "last flag dword", bus_addr[3:2], 3);
      end
      if (backoff) chk(hit_mod && !bus_start, "R7", "during backoff {hitm,ads}",
                       {hit_mod, bus_start}, 2'b10);
      if (upd_valid) begin
        if (exp_upd.size() == 0) begin
          chk(1'b0, "R2", "unexpected update", upd_state, 0);
        end else begin
          e_upd = exp_upd.pop_front();
          chk(upd_state == e_upd.st && upd_line == e_upd.line, "R8", "update {state,line}",
              {upd_state, upd_line}, {e_upd.st, e_upd.line});
        end
      end
      if (hit_mod) hitm_cnt++;
      if (hitm_prev && !hit_mod) begin
        chk(upd_valid, "R8", "update with flag fall", upd_valid, 1);
        if (exp_len >= 0) chk(hitm_cnt == exp_len, nb_mode ? "R6" : "R1",
                              "flag length", hitm_cnt, exp_len);
        chk(blast_cnt == 1, "R5", "last flag count", blast_cnt, 1);
        hitm_cnt  = 0;
        blast_cnt = 0;
        wb_done++;
      end
      hitm_prev = hit_mod;
      fill_prev = fill_busy;

      if (boff_left > 0) begin
        backoff = 1'b1; rdy = 1'b0; brdy = 1'b0;
        boff_left--;
      end else if (open && ack_cnt == boff_at) begin
        backoff = 1'b1; rdy = 1'b0; brdy = 1'b0;
        boff_left = boff_len - 1;
        open = 1'b0;
        boff_at = -1;
      end else begin
        backoff = 1'b0;
        if (open) begin
          rdy  = nb_mode;
          brdy = !nb_mode;
          ack_cnt++;
          if (nb_mode || bus_last) open = 1'b0;
        end else begin
          rdy = 1'b0; brdy = 1'b0;
        end
      end
      if (bus_start) open = 1'b1;
    end
  end

  task automatic snoop(input bit hold, input logic [LW-1:0] line, input bit inv,
                       input bit hit, input logic [1:0] st);
    @(posedge clk); #2;
    addr_hold = hold; snp_strobe = 1'b1; snp_line = line;
    snp_inv = inv; tag_hit = hit; tag_state = st;
    @(posedge clk); #2;
    snp_strobe = 1'b0; addr_hold = 1'b0; tag_hit = 1'b0; tag_state = 2'd0;
  endtask

  task automatic run_wb(input string req, input bit nb, input bit inv,
                        input logic [LW-1:0] line, input int bat, input int blen,
                        input int fill_extra);
    int tgt;
    nb_mode = nb; boff_at = bat; boff_len = blen; ack_cnt = 0;
    exp_len = (bat >= 0 || fill_extra > 0) ? -1 : (nb ? 9 : 6);
    if (bat >= 0) exp_addr.push_back({line, 2'd0, 2'b00});
    if (nb) begin
      for (int i = 0; i < 4; i++) exp_addr.push_back({line, i[1:0], 2'b00});
    end else begin
      exp_addr.push_back({line, 2'd0, 2'b00});
    end
    exp_upd.push_back('{inv ? 2'd0 : 2'd1, line});
    tgt = wb_done + 1;
    if (fill_extra > 0) begin
      @(posedge clk); #2;
      fill_busy = 1'b1;
    end
    snoop(1'b1, line, inv, 1'b1, 2'd3);
    chk(hit_mod == 1'b1, (fill_extra > 0) ? "R9" : "R1", {req, " flag after snoop"}, hit_mod, 1);
    if (fill_extra > 0) begin
      for (int i = 0; i < fill_extra; i++) begin
        @(negedge clk);
        chk(hit_mod && !bus_start, "R9", "held during fill {hitm,ads}", {hit_mod, bus_start}, 2'b10);
      end
      @(posedge clk); #2;
      fill_busy = 1'b0;
    end
    wait (wb_done == tgt);
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic plain(input string req, input bit hold, input logic [LW-1:0] line,
                       input bit inv, input bit hit, input logic [1:0] st, input bit exp_u);
    if (exp_u) exp_upd.push_back('{2'd0, line});
    snoop(hold, line, inv, hit, st);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!hit_mod && !bus_start, req, "no flag, no strobe", {hit_mod, bus_start}, 0);
    end
    chk(exp_upd.size() == 0, req, "pending updates", exp_upd.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_hold = 1'b0; snp_strobe = 1'b0; snp_inv = 1'b0;
    snp_line = '0; tag_hit = 1'b0; tag_state = 2'd0; fill_busy = 1'b0;
    rdy = 1'b0; brdy = 1'b0; backoff = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    chk(!hit_mod && !bus_start && !bus_last && !upd_valid, "R10", "outputs in reset",
        {hit_mod, bus_start, bus_last, upd_valid}, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hit_mod && !bus_start && !upd_valid, "R10", "outputs after reset",
        {hit_mod, bus_start, upd_valid}, 0);

    run_wb("R5", 1'b0, 1'b1, 28'h0ABCDE1, -1, 0, 0);
    run_wb("R6", 1'b1, 1'b0, 28'h1234567, -1, 0, 0);
    run_wb("R7", 1'b0, 1'b1, 28'h0F0F0F0, 2, 3, 0);
    run_wb("R9", 1'b0, 1'b0, 28'h7654321, -1, 0, 5);
    plain("R2", 1'b1, 28'h0000111, 1'b1, 1'b1, 2'd1, 1'b1);
    plain("R2", 1'b1, 28'h0000222, 1'b0, 1'b1, 2'd2, 1'b0);
    plain("R2", 1'b1, 28'h0000333, 1'b1, 1'b0, 2'd3, 1'b0);
    plain("R3", 1'b0, 28'h0000444, 1'b1, 1'b1, 2'd3, 1'b0);
    run_wb("R8", 1'b1, 1'b1, 28'hFEDCBA9, -1, 0, 0);

    chk(exp_addr.size() == 0, "R5", "strobes left", exp_addr.size(), 0);
    chk(exp_upd.size() == 0, "R8", "updates left", exp_upd.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule